// File: doc/BRIEF.md
# Transmit Descriptor Ring Reader

This block is the transmit half of a bus-mastering network controller. It walks a ring of four-word descriptors held in host memory through a single 16-bit word read/write port, streams the bytes of every buffer the host has handed over, and then returns each descriptor with its completion status filled in. A polling pass starts on a periodic tick from outside or on a transmit-demand pulse. A demand or tick that arrives while a pass is already running is latched. The result of each frame (retry class, deferral, lost carrier, late collision, underflow) comes from a stub MAC. The block samples it on the cycle of the frame's final byte.

Each descriptor occupies four consecutive words from `ring_base + 4*index`. Their roles are as follows:
- Word +0 holds bits 15:0 of the buffer's word address.
- Word +1 holds the flag byte in bits 15:8 and bits 23:16 of the buffer address in bits 7:0.
- Word +2 holds the two's-complement negated byte count.
- Word +3 receives the status.

The ring has 2^k entries, with k taken from bits 15:13 of the ring-length word. Buffer bytes go out low byte of each word first.

Top module: `tx_desc_ring_reader`

## Requirements
- R1: After reset, `mem_req`, `tx_valid`, `tx_last`, `tx_int` and `halted` are 0, and the ring index is 0.
- R2: A poll reads word +1 of the current descriptor. If flag bit 7 (owner) is 0, the block streams nothing, writes nothing and keeps the same index, then waits for the next demand or tick.
- R3: Word +2 is the byte count negated in 16 bits, with bits 15:12 at 1. Exactly that many bytes are streamed from the buffer, low byte of each word before its high byte.
- R4: `tx_last` is high only on the final byte of a descriptor whose flag bit 0 (end of packet) is set. A descriptor without it is released, and the next descriptor is fetched at once with no new demand, continuing the same frame.
- R5: The status word written to word +3 of an end-of-packet descriptor has these bits, with bits 9:0 and bit 13 at 0:
  - bit 10: retries = 3 (failed after 16 attempts)
  - bit 11: lost carrier
  - bit 12: late collision
  - bit 14: underflow
  A descriptor without end of packet gets status 0.
- R6: The flag write-back to word +1 follows the status write. It clears bit 7 and keeps bits 1 (start) and 0 (end). For an end-of-packet descriptor it also sets the following bits, all of which are 0 otherwise:
  - bit 6: any of status bits 15:10 set
  - bit 4: retries ≥ 2
  - bit 3: retries = 1
  - bit 2: deferred
  Bits 7:0 of word +1 are written back unchanged.
- R7: `tx_int` is a one-cycle pulse in the cycle after the flag write of an end-of-packet descriptor, or of a buffer error. No pulse follows a descriptor without end of packet.
- R8: After each released descriptor, the index advances by one and wraps with mask 2^k−1.
- R9: The block leaves idle on `tx_demand` or `poll_tick`. One of them seen while busy is held and starts a new pass once the block returns to idle. After an end-of-packet descriptor the block goes idle.
- R10: The MAC outcome inputs are sampled in the cycle where `tx_last` is high.
- R11: An owned descriptor without end of packet at the last ring index raises a buffer error, and its buffer is not read. The block writes status 16'h8000, then the flag with bit 6 set and bit 7 cleared, pulses `tx_int` and sets `halted`. It then issues no memory access or byte until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ring_base | input | AW | Word address of descriptor 0 (multiple of 4) |
| ring_len_word | input | 16 | Bits 15:13 hold log2 of the ring size |
| tx_demand | input | 1 | Request an immediate poll |
| poll_tick | input | 1 | Periodic poll request |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Word address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid the cycle after a read request |
| tx_valid | output | 1 | Byte present on `tx_data` |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | Final byte of a frame |
| mac_retries | input | 2 | 0 none, 1 one retry, 2 several, 3 failed after 16 |
| mac_deferred | input | 1 | Transmission was deferred |
| mac_late_col | input | 1 | Late collision |
| mac_no_carrier | input | 1 | Carrier lost |
| mac_underflow | input | 1 | Data arrived too late |
| tx_int | output | 1 | Transmit-complete pulse |
| halted | output | 1 | Stopped after a buffer error |

## Verification
The checks assume that the memory answers every read exactly one cycle later, and that `ring_base` is a multiple of four, so that word +1 of a descriptor is recognised by address bits 1:0. They also assume the host writes a descriptor's flag word only while the block cannot be reading it. The stimulus keeps to these rules in three ways:
- The bench memory has a fixed one-cycle read latency.
- The ring sits at word 0.
- Every descriptor is prepared while the block is idle, or in a slot it has not yet reached, and its owner flag is written last.

The MAC outcome inputs are held constant for the duration of each frame.

// File: rtl/tdr_pkg.sv
// Shared definitions for the transmit descriptor ring reader.
// Assumes flag bit positions are fixed by the host software contract.
package tdr_pkg;

    localparam int FLAG_OWN  = 7;
    localparam int FLAG_ERR  = 6;
    localparam int FLAG_MORE = 4;
    localparam int FLAG_ONE  = 3;
    localparam int FLAG_DEF  = 2;
    localparam int FLAG_STP  = 1;
    localparam int FLAG_ENP  = 0;

    typedef struct packed {
        logic [1:0] retries;
        logic       deferred;
        logic       late_col;
        logic       no_carrier;
        logic       underflow;
    } tx_outcome_t;

    typedef enum logic [3:0] {
        S_IDLE, S_FLAG_RQ, S_BASE_RQ, S_LEN_RQ, S_LEN_CAP,
        S_DRD, S_DLO, S_DHI, S_WSTAT, S_WFLAG, S_HALT
    } rd_state_t;

endpackage

// File: rtl/tdr_ring_ptr.sv
// Ring index and descriptor address generator.
// Holds the current ring index, wraps it with a mask derived from the
// log2 ring size, and flags the last slot. Assumes AW >= IW + 2.
module tdr_ring_ptr #(
    parameter int AW = 10,
    parameter int IW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ring_base,
    input  logic [2:0]    ring_log2,
    input  logic          advance,
    output logic [AW-1:0] desc_addr,
    output logic          at_last
);
    logic [IW-1:0] idx;
    logic [IW-1:0] mask;

    // Mask of valid index bits for the configured ring size.
    always_comb mask = ~({IW{1'b1}} << ring_log2);

    // Index register: moves to the next slot with wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)       idx <= '0;
        else if (advance) idx <= (idx + 1'b1) & mask;
    end

    // Word address of the current descriptor and last-slot flag.
    always_comb begin
        desc_addr = ring_base + AW'({idx, 2'b00});
        at_last   = (idx == mask);
    end
endmodule

// File: rtl/tdr_status_pack.sv
// Composes the completion status word and the returned flag byte.
// Assumes the outcome is only meaningful for an end-of-packet descriptor.
module tdr_status_pack
    import tdr_pkg::*;
(
    input  logic [7:0]  flag_in,
    input  logic        buf_err,
    input  tx_outcome_t outcome,
    output logic [15:0] status_word,
    output logic [7:0]  flag_out
);
    logic eop;

    // Pack status bits, then derive the summary and retry flags.
    always_comb begin
        eop         = flag_in[FLAG_ENP];
        status_word = '0;
        status_word[15] = buf_err;
        status_word[14] = eop & outcome.underflow;
        status_word[12] = eop & outcome.late_col;
        status_word[11] = eop & outcome.no_carrier;
        status_word[10] = eop & (outcome.retries == 2'd3);
        flag_out            = '0;
        flag_out[FLAG_ERR]  = |status_word[15:10];
        flag_out[FLAG_MORE] = eop & (outcome.retries >= 2'd2);
        flag_out[FLAG_ONE]  = eop & (outcome.retries == 2'd1);
        flag_out[FLAG_DEF]  = eop & outcome.deferred;
        flag_out[FLAG_STP]  = flag_in[FLAG_STP];
        flag_out[FLAG_ENP]  = flag_in[FLAG_ENP];
    end
endmodule

// File: rtl/tx_desc_ring_reader.sv
// Transmit descriptor ring reader.
// Polls the current descriptor on a demand or tick, streams its buffer
// bytes (low byte first), writes status then the flag with ownership
// cleared, and pulses tx_int at the end of a frame. Assumes one-cycle
// read latency on the memory port and a ring base aligned to 4 words.
module tx_desc_ring_reader
    import tdr_pkg::*;
#(
    parameter int AW = 10,
    parameter int IW = 7,
    parameter int CW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ring_base,
    input  logic [15:0]   ring_len_word,
    input  logic          tx_demand,
    input  logic          poll_tick,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [15:0]   mem_wdata,
    input  logic [15:0]   mem_rdata,
    output logic          tx_valid,
    output logic [7:0]    tx_data,
    output logic          tx_last,
    input  logic [1:0]    mac_retries,
    input  logic          mac_deferred,
    input  logic          mac_late_col,
    input  logic          mac_no_carrier,
    input  logic          mac_underflow,
    output logic          tx_int,
    output logic          halted
);
    rd_state_t     state;
    logic [AW-1:0] desc_addr;
    logic          at_last;
    logic          advance;
    logic          pend;
    logic          kick;
    logic [7:0]    flag_q;
    logic [7:0]    base_hi_q;
    logic [AW-1:0] buf_addr;
    logic [CW-1:0] remain;
    logic [7:0]    hi_q;
    logic          buf_err_q;
    logic          int_q;
    tx_outcome_t   outcome_q;
    logic [15:0]   status_word;
    logic [7:0]    flag_out;
    logic [15:0]   neg_len;
    logic [23:0]   full_base;

    tdr_ring_ptr #(.AW(AW), .IW(IW)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .ring_base (ring_base),
        .ring_log2 (ring_len_word[15:13]),
        .advance   (advance),
        .desc_addr (desc_addr),
        .at_last   (at_last)
    );

    tdr_status_pack u_pack (
        .flag_in     (flag_q),
        .buf_err     (buf_err_q),
        .outcome     (outcome_q),
        .status_word (status_word),
        .flag_out    (flag_out)
    );

    // Poll request now or latched earlier.
    always_comb kick = pend | tx_demand | poll_tick;

    // Byte count from the negated length and the full buffer address.
    always_comb begin
        neg_len   = 16'h0000 - mem_rdata;
        full_base = {base_hi_q, mem_rdata};
    end

    // Memory port driven from the current state.
    always_comb begin
        mem_req   = 1'b1;
        mem_we    = 1'b0;
        mem_addr  = desc_addr;
        mem_wdata = '0;
        unique case (state)
            S_FLAG_RQ: mem_addr = desc_addr + AW'(1);
            S_BASE_RQ: mem_addr = desc_addr;
            S_LEN_RQ:  mem_addr = desc_addr + AW'(2);
            S_DRD:     mem_addr = buf_addr;
            S_WSTAT: begin
                mem_we    = 1'b1;
                mem_addr  = desc_addr + AW'(3);
                mem_wdata = status_word;
            end
            S_WFLAG: begin
                mem_we    = 1'b1;
                mem_addr  = desc_addr + AW'(1);
                mem_wdata = {flag_out, base_hi_q};
            end
            default: mem_req = 1'b0;
        endcase
    end

    // Byte stream outputs.
    always_comb begin
        tx_valid = (state == S_DLO) || (state == S_DHI);
        tx_data  = (state == S_DLO) ? mem_rdata[7:0] : hi_q;
        tx_last  = tx_valid && (remain == CW'(1)) && flag_q[FLAG_ENP];
        advance  = (state == S_WFLAG) && !buf_err_q;
        tx_int   = int_q;
        halted   = (state == S_HALT);
    end

    // Latch of poll requests that arrive while busy.
    always_ff @(posedge clk) begin
        if (!rst_n)                pend <= 1'b0;
        else if (state == S_IDLE)  pend <= 1'b0;
        else if (state != S_HALT)  pend <= pend | tx_demand | poll_tick;
    end

    // Main sequencer: fetch, stream, write back, release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            flag_q    <= '0;
            base_hi_q <= '0;
            buf_addr  <= '0;
            remain    <= '0;
            hi_q      <= '0;
            buf_err_q <= 1'b0;
            int_q     <= 1'b0;
            outcome_q <= '0;
        end else begin
            int_q <= 1'b0;
            unique case (state)
                S_IDLE: if (kick) state <= S_FLAG_RQ;
                S_FLAG_RQ: state <= S_BASE_RQ;
                S_BASE_RQ: begin
                    flag_q    <= mem_rdata[15:8];
                    base_hi_q <= mem_rdata[7:0];
                    buf_err_q <= mem_rdata[8+FLAG_OWN] && !mem_rdata[8+FLAG_ENP] && at_last;
                    if (!mem_rdata[8+FLAG_OWN])
                        state <= S_IDLE;
                    else if (!mem_rdata[8+FLAG_ENP] && at_last)
                        state <= S_WSTAT;
                    else
                        state <= S_LEN_RQ;
                end
                S_LEN_RQ: begin
                    buf_addr <= full_base[AW-1:0];
                    state    <= S_LEN_CAP;
                end
                S_LEN_CAP: begin
                    remain <= neg_len[CW-1:0];
                    state  <= S_DRD;
                end
                S_DRD: state <= S_DLO;
                S_DLO, S_DHI: begin
                    if (state == S_DLO) hi_q <= mem_rdata[15:8];
                    else                buf_addr <= buf_addr + AW'(1);
                    if (tx_last)
                        outcome_q <= '{mac_retries, mac_deferred, mac_late_col,
                                       mac_no_carrier, mac_underflow};
                    remain <= remain - CW'(1);
                    if (remain == CW'(1))  state <= S_WSTAT;
                    else if (state == S_DLO) state <= S_DHI;
                    else                     state <= S_DRD;
                end
                S_WSTAT: state <= S_WFLAG;
                S_WFLAG: begin
                    int_q <= flag_q[FLAG_ENP] | buf_err_q;
                    if (buf_err_q)              state <= S_HALT;
                    else if (flag_q[FLAG_ENP])  state <= S_IDLE;
                    else                        state <= S_FLAG_RQ;
                end
                default: state <= S_HALT;
            endcase
        end
    end
endmodule

// File: rtl/tdr_checker.sv
// Port-level properties of the transmit descriptor ring reader.
// Assumes ring_base is a multiple of 4, so word +1 has address bits 01.
module tdr_checker #(
    parameter int AW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [15:0]   mem_wdata,
    input logic          tx_valid,
    input logic          tx_last,
    input logic          tx_int,
    input logic          halted
);
    p_last_in_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last |-> tx_valid);

    p_flag_write_frees_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_addr[1:0] == 2'b01) |-> !mem_wdata[15]);

    p_int_after_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_int |-> $past(mem_req && mem_we && mem_addr[1:0] == 2'b01));

    p_int_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_int |=> !tx_int);

    p_no_write_while_stream_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> !mem_we);

    p_halt_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!mem_req && !tx_valid));

    p_halt_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);
endmodule

bind tx_desc_ring_reader tdr_checker #(.AW(AW)) u_tdr_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .tx_valid  (tx_valid),
    .tx_last   (tx_last),
    .tx_int    (tx_int),
    .halted    (halted)
);

// File: tb/tx_desc_ring_reader_test.sv
// Bench: behavioural host memory plus queues of expected bytes, write-backs
// and interrupts, compared on every clock.
module tx_desc_ring_reader_test;
    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] ring_base = '0;
    logic [15:0]   ring_len_word = 16'h4000;   // log2 = 2, four entries
    logic          tx_demand = 1'b0, poll_tick = 1'b0;
    logic          mem_req, mem_we, tx_valid, tx_last, tx_int, halted;
    logic [AW-1:0] mem_addr;
    logic [15:0]   mem_wdata, mem_rdata;
    logic [7:0]    tx_data;
    logic [1:0]    m_retry = 2'd0;
    logic          m_def = 1'b0, m_late = 1'b0, m_nocar = 1'b0, m_uflo = 1'b0;

    logic [15:0]   mem [0:(1<<AW)-1];
    logic [8:0]    exp_b [$];
    logic [AW+15:0] exp_w [$];
    int            exp_int = 0, got_int = 0;
    int            checks = 0, errors = 0;
    logic          prev_flag_wr = 1'b0;
    bit            finished = 1'b0;

    always #5 clk = ~clk;

    tx_desc_ring_reader #(.AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .ring_len_word(ring_len_word),
        .tx_demand(tx_demand), .poll_tick(poll_tick),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
        .mac_retries(m_retry), .mac_deferred(m_def), .mac_late_col(m_late),
        .mac_no_carrier(m_nocar), .mac_underflow(m_uflo),
        .tx_int(tx_int), .halted(halted)
    );

    // Host memory with one-cycle read latency.
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr];
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Per-clock comparison against the expected event queues.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (tx_valid) begin
                if (exp_b.size() == 0) chk("R2 unexpected byte", {23'd0, tx_last, tx_data}, 32'hFFFF);
                else chk("R3/R4 byte", {23'd0, tx_last, tx_data}, {23'd0, exp_b.pop_front()});
            end
            if (tx_int) begin
                got_int++;
                chk("R7 int follows flag write", {31'd0, prev_flag_wr}, 32'd1);
            end
            prev_flag_wr = mem_req && mem_we && (mem_addr[1:0] == 2'b01);
            if (mem_req && mem_we) begin
                if (exp_w.size() == 0) chk("R2 unexpected write", {mem_addr, mem_wdata}, 32'hFFFF_FFFF);
                else chk("R5/R6 write-back", {mem_addr, mem_wdata}, {6'd0, exp_w.pop_front()});
            end
        end
    end

    function automatic logic [15:0] exp_status(input logic enp);
        logic [15:0] s = '0;
        if (enp) begin
            s[10] = (m_retry == 2'd3);
            s[11] = m_nocar;
            s[12] = m_late;
            s[14] = m_uflo;
        end
        return s;
    endfunction

    // Place one descriptor (flag word last) and queue its expected effects.
    task automatic frame(input int idx, input int n, input logic stp, input logic enp,
                         input logic [7:0] seed);
        int d = idx * 4;
        int b = 16'h100 + idx * 16'h40;
        logic [15:0] st;
        logic [7:0]  fl;
        for (int k = 0; k < n; k++) begin
            logic [7:0] v = seed + 8'(k * 7);
            if (k % 2 == 0) mem[b + k/2][7:0]  = v;
            else            mem[b + k/2][15:8] = v;
            exp_b.push_back({enp && (k == n - 1), v});
        end
        mem[d]     = 16'(b);
        mem[d + 2] = 16'(17'h10000 - n);
        mem[d + 3] = 16'h0;
        mem[d + 1] = {6'b100000, stp, enp, 8'h00};
        st = exp_status(enp);
        fl = {1'b0, |st, 1'b0, enp && (m_retry >= 2'd2), enp && (m_retry == 2'd1),
              enp && m_def, stp, enp};
        exp_w.push_back({AW'(d + 3), st});
        exp_w.push_back({AW'(d + 1), fl, 8'h00});
        if (enp) exp_int++;
    endtask

    task automatic pulse_demand();
        @(negedge clk); tx_demand = 1'b1;
        @(negedge clk); tx_demand = 1'b0;
    endtask

    task automatic drain(input string tag);
        int n = 0;
        while ((exp_b.size() != 0 || exp_w.size() != 0) && n < 20000) begin
            @(negedge clk); n++;
        end
        repeat (12) @(negedge clk);
        chk({tag, " queues drained"}, exp_b.size() + exp_w.size(), 0);
        chk({tag, " interrupt count"}, got_int, exp_int);
    endtask

    initial begin
        repeat (250000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < (1 << AW); i++) mem[i] = 16'h0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 mem_req", {31'd0, mem_req}, 0);
        chk("R1 tx_valid", {31'd0, tx_valid}, 0);
        chk("R1 tx_int", {31'd0, tx_int}, 0);
        chk("R1 halted", {31'd0, halted}, 0);
        rst_n = 1'b1;

        // R3 R5 R6: clean odd-length frame in slot 0
        frame(0, 5, 1'b1, 1'b1, 8'h11); pulse_demand(); drain("R3 clean");
        // R10 R6: one retry, deferred
        m_retry = 2'd1; m_def = 1'b1;
        frame(1, 4, 1'b1, 1'b1, 8'h20); pulse_demand(); drain("R10 one retry");
        // R5: lost carrier and late collision
        m_retry = 2'd0; m_def = 1'b0; m_nocar = 1'b1; m_late = 1'b1;
        frame(2, 6, 1'b1, 1'b1, 8'h31); pulse_demand(); drain("R5 carrier");
        m_nocar = 1'b0; m_late = 1'b0;
        // R2: slot 3 not owned, nothing happens, index stays
        mem[13] = 16'h0300;
        pulse_demand(); drain("R2 not owned");
        chk("R2 flag word untouched", mem[13], 16'h0300);
        // R8 R5: slot 3 now owned, 16-retry failure plus underflow; index wraps after
        m_retry = 2'd3; m_uflo = 1'b1;
        frame(3, 3, 1'b1, 1'b1, 8'h44); pulse_demand(); drain("R5 retry fail");
        m_retry = 2'd0; m_uflo = 1'b0;
        // R4 R8: chained frame over slots 0 and 1 after the wrap
        frame(0, 3, 1'b1, 1'b0, 8'h50);
        frame(1, 4, 1'b0, 1'b1, 8'h60);
        pulse_demand(); drain("R4 chain");
        // R9: second demand while busy is held
        frame(2, 9, 1'b1, 1'b1, 8'h70);
        frame(3, 2, 1'b1, 1'b1, 8'h80);
        pulse_demand(); repeat (4) @(negedge clk);
        pulse_demand(); drain("R9 held demand");
        // R3 R9: one-byte frame started by the periodic tick
        frame(0, 1, 1'b1, 1'b1, 8'h9A);
        @(negedge clk); poll_tick = 1'b1; @(negedge clk); poll_tick = 1'b0;
        drain("R9 tick one byte");
        // R11: no end of packet reaches the last slot
        frame(1, 2, 1'b1, 1'b0, 8'hA0);
        frame(2, 3, 1'b0, 1'b0, 8'hB0);
        mem[12] = 16'h0300; mem[14] = 16'hFFFE; mem[15] = 16'h0;
        mem[13] = 16'h8200;
        exp_w.push_back({AW'(15), 16'h8000});
        exp_w.push_back({AW'(13), 16'h4200});
        exp_int++;
        pulse_demand(); drain("R11 buffer error");
        chk("R11 halted", {31'd0, halted}, 1);
        // R11: halted block ignores a fresh owned descriptor
        mem[1] = 16'h8300;
        pulse_demand(); drain("R11 stays halted");
        chk("R11 descriptor untouched", mem[1], 16'h8300);

        finished = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule